// File: doc/BRIEF.md
# Reset Hold Duration Counter

This block measures how long an external push-button reset line has been held down. The button line is active low and asynchronous. It is brought into the reference clock domain through a short flop chain. While the synchronised level is low, a counter advances once per reference clock cycle. At the nominal 25 MHz reference, one count is 40 ns. With the default 29-bit width the longest measurable hold is about 21.4 s.

The counter does not wrap. It stops at its all-ones value and stays there. When the button is let go, the count freezes, so software can read it at leisure. A later press adds to the frozen value. The only way to zero the count is a register write with the command bit set, or the block reset. A parameter gives the number of counts in one second (25,000,000 by default), so that firmware and benches can turn a threshold in seconds into counts.

Top module: `rsthold_timer`

## Requirements
- R1: While `ref_rst_n` is low, `reg_rdata` reads 0.
- R2: The button passes through two synchroniser flops. A low level present at a rising edge adds one to the count two edges later. The first increment after `button_n` falls is visible after the third rising edge.
- R3: While the synchronised button is high, the count holds its value, however long the wait.
- R4: A new press continues counting from the held value. It does not restart from zero.
- R5: The count saturates at 2^CNT_W-1 (0x1FFF_FFFF for the default CNT_W of 29). Further held cycles leave it at that value.
- R6: `reg_rdata` carries the count in bits CNT_W-1:0. All bits from CNT_W up to 31 read as zero.
- R7: A cycle with `reg_wr` high and `reg_wdata` bit 31 set clears the count to zero at that clock edge.
- R8: A write with bit 31 clear has no effect on the count, whatever the other bits hold.
- R9: When a clear write and an increment fall on the same edge, the clear wins and the count is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock, nominally 25 MHz |
| ref_rst_n | input | 1 | Asynchronous active-low block reset |
| button_n | input | 1 | Asynchronous active-low button level being timed |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data; bit 31 is the clear command |
| reg_rdata | output | 32 | Current count, zero-extended |

## Verification
The bench drives presses of several lengths: single-cycle, short, medium, and long enough to saturate a narrow build. It also drives idle gaps with no press at all. Together these separate counting from freezing, and separate accumulation across presses from a restart. Presses are interleaved with and without a preceding clear, which shows whether the clear is the only thing that zeroes the count. Directed cases cover the exact two-stage latency after the button falls, a clear landing mid-press (separating clear priority from increment), a write without the command bit, a reset during a held count, and saturation on a 5-bit instance running in parallel with the 29-bit one.

// File: rtl/rsthold_pkg.sv
package rsthold_pkg;
   // Default geometry of the hold-duration counter and its register view
   localparam int unsigned DEF_CNT_W       = 29;
   localparam int unsigned DEF_REG_W       = 32;
   localparam int unsigned DEF_CLR_BIT     = 31;
   localparam int unsigned DEF_SYNC_STAGES = 2;
   // Counts per second at the nominal 25 MHz reference (40 ns per count)
   localparam int unsigned DEF_TICK_HZ     = 25_000_000;
endpackage

// File: rtl/rsthold_sync.sv
module rsthold_sync #(
   parameter int unsigned STAGES  = rsthold_pkg::DEF_SYNC_STAGES,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   initial begin
      assert (STAGES >= 2) else $error("rsthold_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rsthold_counter.sv
module rsthold_counter #(
   parameter int unsigned CNT_W = rsthold_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             clear,
   output logic [CNT_W-1:0] count
);
   initial begin
      assert (CNT_W >= 2) else $error("rsthold_counter: CNT_W too small");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic at_max;
   assign at_max = (count == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 count <= '0;
      else if (clear)             count <= '0;
      else if (advance && !at_max) count <= count + CNT_ONE;
   end

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));                                        // R9

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (at_max && !clear) |=> (count == CNT_MAX));                      // R5

   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !clear) |=> $stable(count));                        // R3

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear && !at_max) |=> (count == $past(count) + CNT_ONE)); // R2
endmodule

// File: rtl/rsthold_regif.sv
module rsthold_regif #(
   parameter int unsigned CNT_W   = rsthold_pkg::DEF_CNT_W,
   parameter int unsigned REG_W   = rsthold_pkg::DEF_REG_W,
   parameter int unsigned CLR_BIT = rsthold_pkg::DEF_CLR_BIT
) (
   input  logic [CNT_W-1:0] count,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic             clear,
   output logic [REG_W-1:0] rd_data
);
   initial begin
      assert (CLR_BIT < REG_W) else $error("rsthold_regif: CLR_BIT outside register");
      assert (CNT_W <= CLR_BIT) else $error("rsthold_regif: count overlaps clear bit");
   end

   localparam logic [REG_W-1:0] CLR_MASK = REG_W'(1) << CLR_BIT;

   assign clear = wr_en && wr_data[CLR_BIT];

   // Bits other than the command bit carry no meaning on a write
   logic unused_wr_bits;
   assign unused_wr_bits = ^(wr_data & ~CLR_MASK);

   generate
      if (REG_W > CNT_W) begin : g_pad
         assign rd_data = {{(REG_W-CNT_W){1'b0}}, count};
      end else begin : g_full
         assign rd_data = count;
      end
   endgenerate

   always_comb begin
      if (REG_W > CNT_W) begin
         AST_UPPER_ZERO: assert ((rd_data >> CNT_W) == '0);             // R6
      end
   end
endmodule

// File: rtl/rsthold_timer.sv
module rsthold_timer #(
   parameter int unsigned CNT_W       = rsthold_pkg::DEF_CNT_W,
   parameter int unsigned REG_W       = rsthold_pkg::DEF_REG_W,
   parameter int unsigned CLR_BIT     = rsthold_pkg::DEF_CLR_BIT,
   parameter int unsigned SYNC_STAGES = rsthold_pkg::DEF_SYNC_STAGES,
   parameter int unsigned TICK_HZ     = rsthold_pkg::DEF_TICK_HZ
) (
   input  logic             ref_clk,
   input  logic             ref_rst_n,
   input  logic             button_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata
);
   initial begin
      assert (TICK_HZ > 0) else $error("rsthold_timer: TICK_HZ must be non-zero");
      assert (CNT_W < REG_W) else $error("rsthold_timer: count wider than register");
   end

   logic             btn_sync_n;
   logic             held;
   logic             clr_cmd;
   logic [CNT_W-1:0] cnt;

   rsthold_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) i_sync (
      .clk     (ref_clk),
      .rst_n   (ref_rst_n),
      .d_async (button_n),
      .q_sync  (btn_sync_n)
   );

   assign held = !btn_sync_n;

   rsthold_counter #(
      .CNT_W   (CNT_W)
   ) i_counter (
      .clk     (ref_clk),
      .rst_n   (ref_rst_n),
      .advance (held),
      .clear   (clr_cmd),
      .count   (cnt)
   );

   rsthold_regif #(
      .CNT_W   (CNT_W),
      .REG_W   (REG_W),
      .CLR_BIT (CLR_BIT)
   ) i_regif (
      .count   (cnt),
      .wr_en   (reg_wr),
      .wr_data (reg_wdata),
      .clear   (clr_cmd),
      .rd_data (reg_rdata)
   );

   AST_RESET_ZERO: assert property (@(posedge ref_clk)
      !ref_rst_n |-> (reg_rdata == '0));                               // R1

   AST_WRITE_CLEARS: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (reg_wr && reg_wdata[CLR_BIT]) |=> (reg_rdata == '0));           // R7
endmodule

// File: tb/test_rsthold_timer.sv
module test_rsthold_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        btn_n = 1'b1;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_w;
   logic [31:0] rd_n;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   localparam int unsigned NARROW_W = 5;
   localparam logic [31:0] NARROW_MAX = 32'd31;
   localparam logic [31:0] CLR_CMD = 32'h8000_0000;

   always #5 clk = ~clk;

   rsthold_timer i_rsthold_timer (
      .ref_clk(clk), .ref_rst_n(rst_n), .button_n(btn_n),
      .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rd_w));

   rsthold_timer #(.CNT_W(NARROW_W)) i_rsthold_timer_narrow (
      .ref_clk(clk), .ref_rst_n(rst_n), .button_n(btn_n),
      .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rd_n));

   // {clear first, press cycles, expected wide count}
   localparam logic [40:0] VEC [8] = '{
      {1'b1, 8'd10, 32'd10},
      {1'b0, 8'd5,  32'd15},
      {1'b0, 8'd0,  32'd15},
      {1'b1, 8'd1,  32'd1},
      {1'b1, 8'd0,  32'd0},
      {1'b0, 8'd20, 32'd20},
      {1'b0, 8'd20, 32'd40},
      {1'b0, 8'd3,  32'd43}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic write(input logic [31:0] v);
      wr = 1'b1;
      wdata = v;
      tick(1);
      wr = 1'b0;
      wdata = '0;
   endtask

   task automatic press(input int n);
      btn_n = 1'b0;
      tick(n);
      btn_n = 1'b1;
   endtask

   function automatic logic [31:0] narrow_of(input logic [31:0] v);
      return (v > NARROW_MAX) ? NARROW_MAX : v;
   endfunction

   initial begin
      logic [31:0] nexp;
      tick(3);
      chk("R1 wide in reset", rd_w, 0);
      chk("R1 narrow in reset", rd_n, 0);
      rst_n = 1'b1;
      tick(2);
      chk("R1 wide after reset", rd_w, 0);

      // table walk
      nexp = 0;
      for (int i = 0; i < 8; i++) begin
         if (VEC[i][40]) begin
            write(CLR_CMD);
            nexp = 0;
         end
         if (VEC[i][39:32] != 0) press(int'(VEC[i][39:32]));
         tick(3);
         nexp = narrow_of(nexp + 32'(VEC[i][39:32]));
         chk("R4 R5 R6 wide table", rd_w, VEC[i][31:0]);
         chk("R5 R6 narrow table", rd_n, nexp);
      end

      // R2 latency through the two synchroniser flops
      write(CLR_CMD);
      chk("R7 clear", rd_w, 0);
      btn_n = 1'b0;
      tick(2);
      chk("R2 no count after two edges", rd_w, 0);
      tick(1);
      chk("R2 first count after third edge", rd_w, 1);
      tick(1);
      chk("R2 second count", rd_w, 2);
      btn_n = 1'b1;
      tick(3);
      chk("R2 total after release", rd_w, 4);

      // R3 frozen over a long idle gap
      tick(50);
      chk("R3 held after idle", rd_w, 4);
      chk("R3 narrow held after idle", rd_n, 4);

      // R9 clear in the same cycle as an increment
      write(CLR_CMD);
      btn_n = 1'b0;
      tick(10);
      wr = 1'b1;
      wdata = CLR_CMD;
      tick(1);
      wr = 1'b0;
      wdata = '0;
      chk("R9 clear beats increment", rd_w, 0);
      chk("R9 narrow clear beats increment", rd_n, 0);
      tick(1);
      btn_n = 1'b1;
      tick(3);
      chk("R9 count resumes after clear", rd_w, 3);

      // R5 saturation on the narrow build, with the press still active
      write(CLR_CMD);
      btn_n = 1'b0;
      tick(100);
      chk("R5 narrow stays at max while held", rd_n, NARROW_MAX);
      chk("R2 wide while held", rd_w, 98);
      btn_n = 1'b1;
      tick(3);
      chk("R5 narrow no wrap", rd_n, NARROW_MAX);
      chk("R6 wide upper bits zero", {29'd0, rd_w[31:29]}, 0);

      // R8 write without the command bit
      write(32'h7FFF_FFFF);
      tick(1);
      chk("R8 write without bit 31 ignored", rd_w, 100);
      chk("R8 narrow write without bit 31 ignored", rd_n, NARROW_MAX);

      // R1 reset during a held count
      rst_n = 1'b0;
      tick(1);
      chk("R1 reset clears wide", rd_w, 0);
      chk("R1 reset clears narrow", rd_n, 0);
      rst_n = 1'b1;
      tick(2);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule